// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block collects a parameterised set of shared interrupt inputs, conditions each one according to its own sensing mode, and steers it to one of several processor contexts and to one numbered request pin within that context. Each source can be sensed in one of three ways. It can follow a level of either polarity. It can latch on a single edge of either direction. It can latch on both edges, and in that case the polarity setting is ignored. Software reaches the block over a simple 32-bit register bus with one-cycle read latency. It enables and disables sources through separate write-one set and clear mask registers. It reads pending and mask state as packed bit vectors. It can inject or withdraw a pending state for any source by number through a single command word. The inject path doubles as an inter-processor doorbell. The withdraw path acknowledges edge-latched sources.

Every context has one request output, and every context/pin pair has one request output. Both are registered.

Top module: `shirq_ctrl`

## Requirements
- R1: A read of byte address 0x000 returns the group count minus one in bits [7:0], the context count minus one in bits [15:8] and the pin count minus one in bits [23:16]. The source count equals (bits[7:0]+1)*8.
- R2: After reset every source has positive polarity (bit 1), level trigger (bit 0), dual-edge off (bit 0) and is masked. Every pin map reads 0 (not valid, pin 0). Every context map reads 0x1. Both request output buses are 0.
- R3: The set-mask bank (region 5) enables each source whose written bit is 1 and leaves the others unchanged. The mask bank (region 7) reads back 1 for enabled sources.
- R4: The clear-mask bank (region 6) disables each source whose written bit is 1 and leaves the others unchanged. The mask state changes only through region 5 or region 6 writes.
- R5: A source in level mode (trigger bit 0) is pending exactly while its input equals its polarity bit, where 1 means high-active and 0 means low-active.
- R6: A source in edge mode (trigger bit 1) with dual-edge 0 latches pending on a rising input edge when its polarity is 1 and on a falling edge when its polarity is 0. The latch holds until a command-word clear for that source.
- R7: A source in edge mode with dual-edge 1 latches pending on both input edges, whatever its polarity bit.
- R8: A write to the command word (byte 0x004) with bit 31 = 1 makes the source numbered by bits [15:0] pending, and with bit 31 = 0 removes its latched pending state. A number at or above the source count has no effect. A level source whose input is active stays pending after a clear.
- R9: Bank regions sit at byte address region*0x80, with word k at +4k. Bit i of word k is source 32k+i. The regions are polarity 2, trigger 3, dual-edge 4, set-mask 5, clear-mask 6, mask 7 and pending 8.
- R10: The pin map of source s sits at 0x1000+4s, with bit 31 as the valid flag and the low bits as the pin. A source whose valid flag is 0 drives no request output.
- R11: The context map of source s sits at 0x2000+4s and holds a one-hot context select. A written value with several bits set keeps only its lowest set bit. A value with no bit set inside the context range leaves the map unchanged.
- R12: ctx_irq[c] is the OR, over sources mapped to context c with a valid pin, of pending AND enabled, registered once. pin_irq[c*NPIN+p] is the same OR restricted to pin p.
- R13: Read data appears on bus_rdata the cycle after bus_rd. It is zero in every cycle without a read in the previous cycle, and zero for the write-only regions (1 word 1, 5, 6) and for unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NSRC | Shared interrupt inputs, already synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 14 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| ctx_irq | output | NCTX | Per-context request |
| pin_irq | output | NCTX*NPIN | Per context/pin request, index c*NPIN+p |

## Verification
Several properties are checked on every cycle. Each context output must equal the pending-enabled-routed OR from the cycle before. A pin request must never appear without its context request. The mask may rise only after a set-mask write and fall only after a clear-mask write. An edge-latched source may lose its pending state only after a command-word clear naming it. Idle read data must be zero, and the reset state must follow reset. The bench scenarios are needed for the rest. They cover the polarity and trigger combinations swept over many input patterns, the dual-edge behaviour that ignores polarity, the rejection of out-of-range command numbers, the reduction of a multi-bit context write to one bit, and the word/bit layout of the banks across the partial last word.

// File: rtl/shirq_pkg.sv
package shirq_pkg;
  localparam int REG_W        = 32;
  localparam int ADDR_W       = 14;
  localparam int WEDGE_SET    = 31;
  localparam int WEDGE_IDX_W  = 16;
  localparam int PIN_VLD_BIT  = 31;

  // bank region codes, address bits [11:7] inside space 0
  localparam logic [4:0] BK_CTRL  = 5'd0;
  localparam logic [4:0] BK_POL   = 5'd2;
  localparam logic [4:0] BK_TRIG  = 5'd3;
  localparam logic [4:0] BK_DUAL  = 5'd4;
  localparam logic [4:0] BK_SMASK = 5'd5;
  localparam logic [4:0] BK_RMASK = 5'd6;
  localparam logic [4:0] BK_MASK  = 5'd7;
  localparam logic [4:0] BK_PEND  = 5'd8;

  typedef enum logic [1:0] {
    SP_BANKS  = 2'd0,
    SP_PINMAP = 2'd1,
    SP_CTXMAP = 2'd2,
    SP_NONE   = 2'd3
  } space_e;

  typedef struct packed {
    space_e     space;
    logic [4:0] bank;
    logic [4:0] word;
    logic [9:0] idx;
  } dec_t;

  function automatic dec_t decode(input logic [ADDR_W-1:0] a);
    dec_t d;
    d.space = space_e'(a[13:12]);
    d.bank  = a[11:7];
    d.word  = a[6:2];
    d.idx   = a[11:2];
    return d;
  endfunction

  function automatic int width_of(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/shirq_src_cell.sv
module shirq_src_cell (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic pol,
  input  logic trig,
  input  logic dual,
  input  logic sw_set,
  input  logic sw_clr,
  output logic pend
);
  logic prev_q, latch_q;
  logic rise, fall, edge_hit, lvl_act;

  always_comb begin
    rise     = din & ~prev_q;
    fall     = ~din & prev_q;
    edge_hit = trig & (dual ? (rise | fall) : (pol ? rise : fall));
    lvl_act  = ~trig & (din == pol);
  end

  // a detected edge wins over a same-cycle clear so no edge is lost
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= din;
      if (edge_hit || sw_set)
        latch_q <= 1'b1;
      else if (sw_clr)
        latch_q <= 1'b0;
    end
  end

  assign pend = lvl_act | latch_q;
endmodule

// File: rtl/shirq_regs.sv
module shirq_regs
  import shirq_pkg::*;
#(
  parameter int NGRP = 5,
  parameter int NCTX = 3,
  parameter int NPIN = 4,
  localparam int NSRC  = NGRP * 8,
  localparam int CTX_W = width_of(NCTX),
  localparam int PIN_W = width_of(NPIN)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [REG_W-1:0]             bus_wdata,
  output logic [REG_W-1:0]             bus_rdata,
  input  logic [NSRC-1:0]              pend,
  output logic [NSRC-1:0]              pol,
  output logic [NSRC-1:0]              trig,
  output logic [NSRC-1:0]              dual,
  output logic [NSRC-1:0]              mask,
  output logic [NSRC-1:0]              pin_vld,
  output logic [NSRC-1:0][PIN_W-1:0]   pin_sel,
  output logic [NSRC-1:0][CTX_W-1:0]   ctx_sel,
  output logic [NSRC-1:0]              sw_set,
  output logic [NSRC-1:0]              sw_clr
);
  localparam int WORDS = (NSRC + 31) / 32;
  localparam int PADW  = WORDS * 32;
  localparam int IDX_W = width_of(NSRC);
  localparam logic [9:0]             NSRC_L  = 10'(NSRC);
  localparam logic [4:0]             WORDS_L = 5'(WORDS);
  localparam logic [WEDGE_IDX_W-1:0] NSRC_W  = WEDGE_IDX_W'(NSRC);

  dec_t d;
  assign d = decode(bus_addr);

  logic unused_addr_lsb;
  assign unused_addr_lsb = ^bus_addr[1:0];

  logic bank_wr, idx_ok;
  assign bank_wr = bus_wr && (d.space == SP_BANKS);
  assign idx_ok  = (d.idx < NSRC_L);

  // ---------------- per-source setting banks ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      pol  <= '1;
      trig <= '0;
      dual <= '0;
      mask <= '0;
    end else if (bank_wr) begin
      for (int s = 0; s < NSRC; s++) begin
        if (d.word == 5'(s / 32)) begin
          case (d.bank)
            BK_POL:   pol[s]  <= bus_wdata[s % 32];
            BK_TRIG:  trig[s] <= bus_wdata[s % 32];
            BK_DUAL:  dual[s] <= bus_wdata[s % 32];
            BK_SMASK: if (bus_wdata[s % 32]) mask[s] <= 1'b1;
            BK_RMASK: if (bus_wdata[s % 32]) mask[s] <= 1'b0;
            default: ;
          endcase
        end
      end
    end
  end

  // ---------------- routing maps ----------------
  logic [CTX_W-1:0] ctx_low;
  logic             ctx_any;

  always_comb begin
    ctx_low = '0;
    ctx_any = 1'b0;
    for (int c = NCTX - 1; c >= 0; c--) begin
      if (bus_wdata[c]) begin
        ctx_low = CTX_W'(c);
        ctx_any = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_vld <= '0;
      pin_sel <= '0;
      ctx_sel <= '0;
    end else if (bus_wr && idx_ok) begin
      if (d.space == SP_PINMAP) begin
        pin_vld[d.idx[IDX_W-1:0]] <= bus_wdata[PIN_VLD_BIT];
        pin_sel[d.idx[IDX_W-1:0]] <= bus_wdata[PIN_W-1:0];
      end
      if (d.space == SP_CTXMAP && ctx_any)
        ctx_sel[d.idx[IDX_W-1:0]] <= ctx_low;
    end
  end

  // ---------------- software inject / withdraw ----------------
  logic [WEDGE_IDX_W-1:0] widx;
  logic                   wedge_hit;
  assign widx      = bus_wdata[WEDGE_IDX_W-1:0];
  assign wedge_hit = bank_wr && (d.bank == BK_CTRL) && (d.word == 5'd1) && (widx < NSRC_W);

  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      sw_set[s] = wedge_hit && bus_wdata[WEDGE_SET]  && (widx == WEDGE_IDX_W'(s));
      sw_clr[s] = wedge_hit && !bus_wdata[WEDGE_SET] && (widx == WEDGE_IDX_W'(s));
    end
  end

  // ---------------- readback ----------------
  function automatic logic [REG_W-1:0] pick(input logic [PADW-1:0] v, input logic [4:0] w);
    logic [REG_W-1:0] r;
    r = '0;
    for (int k = 0; k < WORDS; k++)
      if (w == 5'(k)) r = v[k*32 +: 32];
    return r;
  endfunction

  logic [PADW-1:0]  pol_p, trig_p, dual_p, mask_p, pend_p;
  logic [REG_W-1:0] cfg_word, rd_word;
  logic [NCTX-1:0]  ctx_oh;

  assign pol_p  = PADW'(pol);
  assign trig_p = PADW'(trig);
  assign dual_p = PADW'(dual);
  assign mask_p = PADW'(mask);
  assign pend_p = PADW'(pend);
  assign cfg_word = {8'd0, 8'(NPIN - 1), 8'(NCTX - 1), 8'(NGRP - 1)};
  assign ctx_oh = NCTX'(1) << ctx_sel[d.idx[IDX_W-1:0]];

  always_comb begin
    rd_word = '0;
    case (d.space)
      SP_BANKS: begin
        if (d.bank == BK_CTRL) begin
          if (d.word == 5'd0) rd_word = cfg_word;
        end else if (d.word < WORDS_L) begin
          case (d.bank)
            BK_POL:  rd_word = pick(pol_p, d.word);
            BK_TRIG: rd_word = pick(trig_p, d.word);
            BK_DUAL: rd_word = pick(dual_p, d.word);
            BK_MASK: rd_word = pick(mask_p, d.word);
            BK_PEND: rd_word = pick(pend_p, d.word);
            default: rd_word = '0;
          endcase
        end
      end
      SP_PINMAP:
        if (idx_ok)
          rd_word = {pin_vld[d.idx[IDX_W-1:0]], {(REG_W-1-PIN_W){1'b0}}, pin_sel[d.idx[IDX_W-1:0]]};
      SP_CTXMAP:
        if (idx_ok) rd_word = REG_W'(ctx_oh);
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_rd ? rd_word : '0;
  end
endmodule

// File: rtl/shirq_route.sv
module shirq_route
  import shirq_pkg::*;
#(
  parameter int NSRC = 40,
  parameter int NCTX = 3,
  parameter int NPIN = 4,
  localparam int CTX_W = width_of(NCTX),
  localparam int PIN_W = width_of(NPIN)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NSRC-1:0]            live,
  input  logic [NSRC-1:0][CTX_W-1:0] ctx_sel,
  input  logic [NSRC-1:0][PIN_W-1:0] pin_sel,
  output logic [NCTX-1:0]            ctx_irq,
  output logic [NCTX*NPIN-1:0]       pin_irq
);
  logic [NCTX-1:0]      ctx_d;
  logic [NCTX*NPIN-1:0] pin_d;

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    always_comb begin
      ctx_d[c] = 1'b0;
      for (int s = 0; s < NSRC; s++)
        if (live[s] && ctx_sel[s] == CTX_W'(c)) ctx_d[c] = 1'b1;
    end
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
      always_comb begin
        pin_d[c*NPIN+p] = 1'b0;
        for (int s = 0; s < NSRC; s++)
          if (live[s] && ctx_sel[s] == CTX_W'(c) && pin_sel[s] == PIN_W'(p))
            pin_d[c*NPIN+p] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_irq <= '0;
      pin_irq <= '0;
    end else begin
      ctx_irq <= ctx_d;
      pin_irq <= pin_d;
    end
  end
endmodule

// File: rtl/shirq_ctrl.sv
module shirq_ctrl
  import shirq_pkg::*;
#(
  parameter int NGRP = 5,
  parameter int NCTX = 3,
  parameter int NPIN = 4,
  localparam int NSRC  = NGRP * 8,
  localparam int CTX_W = width_of(NCTX),
  localparam int PIN_W = width_of(NPIN)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSRC-1:0]      src_in,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [REG_W-1:0]     bus_wdata,
  output logic [REG_W-1:0]     bus_rdata,
  output logic [NCTX-1:0]      ctx_irq,
  output logic [NCTX*NPIN-1:0] pin_irq
);
  logic [NSRC-1:0]            pol, trig, dual, mask, pin_vld, sw_set, sw_clr, pend, live;
  logic [NSRC-1:0][PIN_W-1:0] pin_sel;
  logic [NSRC-1:0][CTX_W-1:0] ctx_sel;

  shirq_regs #(.NGRP(NGRP), .NCTX(NCTX), .NPIN(NPIN)) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend(pend), .pol(pol), .trig(trig), .dual(dual), .mask(mask),
    .pin_vld(pin_vld), .pin_sel(pin_sel), .ctx_sel(ctx_sel),
    .sw_set(sw_set), .sw_clr(sw_clr)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    shirq_src_cell u_cell (
      .clk(clk), .rst(rst), .din(src_in[s]),
      .pol(pol[s]), .trig(trig[s]), .dual(dual[s]),
      .sw_set(sw_set[s]), .sw_clr(sw_clr[s]), .pend(pend[s])
    );
  end

  assign live = pend & mask & pin_vld;

  shirq_route #(.NSRC(NSRC), .NCTX(NCTX), .NPIN(NPIN)) u_route (
    .clk(clk), .rst(rst), .live(live),
    .ctx_sel(ctx_sel), .pin_sel(pin_sel),
    .ctx_irq(ctx_irq), .pin_irq(pin_irq)
  );
endmodule

// File: rtl/shirq_ctrl_chk.sv
module shirq_ctrl_chk
  import shirq_pkg::*;
#(
  parameter int NGRP = 5,
  parameter int NCTX = 3,
  parameter int NPIN = 4,
  localparam int NSRC  = NGRP * 8,
  localparam int CTX_W = width_of(NCTX),
  localparam int PIN_W = width_of(NPIN)
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bus_wr,
  input logic                       bus_rd,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [REG_W-1:0]           bus_wdata,
  input logic [REG_W-1:0]           bus_rdata,
  input logic [NCTX-1:0]            ctx_irq,
  input logic [NCTX*NPIN-1:0]       pin_irq,
  input logic [NSRC-1:0]            pend,
  input logic [NSRC-1:0]            mask,
  input logic [NSRC-1:0]            trig,
  input logic [NSRC-1:0]            pin_vld,
  input logic [NSRC-1:0][CTX_W-1:0] ctx_sel
);
  logic [NCTX-1:0] want_ctx;
  always_comb begin
    want_ctx = '0;
    for (int s = 0; s < NSRC; s++)
      if (pend[s] && mask[s] && pin_vld[s]) want_ctx[ctx_sel[s]] = 1'b1;
  end

  logic smask_wr, rmask_wr;
  assign smask_wr = bus_wr && bus_addr[13:12] == 2'd0 && bus_addr[11:7] == 5'd5;
  assign rmask_wr = bus_wr && bus_addr[13:12] == 2'd0 && bus_addr[11:7] == 5'd6;

  // R2
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mask == '0 && ctx_irq == '0 && pin_irq == '0));

  // R3
  mask_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ((mask & ~$past(mask)) != '0) |-> $past(smask_wr));

  // R4
  mask_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ((~mask & $past(mask)) != '0) |-> $past(rmask_wr));

  // R13
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> bus_rdata == '0);

  for (genvar c = 0; c < NCTX; c++) begin : g_c
    // R12
    ctx_out_chk: assert property (@(posedge clk) disable iff (rst)
      ctx_irq[c] == $past(want_ctx[c]));
    // R12
    pin_ctx_chk: assert property (@(posedge clk) disable iff (rst)
      (|pin_irq[c*NPIN +: NPIN]) |-> ctx_irq[c]);
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_s
    // R6
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(trig[s]) && trig[s] && $fell(pend[s])) |->
        $past(bus_wr && bus_addr[13:7] == 7'd0 && bus_addr[6:2] == 5'd1 &&
              !bus_wdata[31] && bus_wdata[15:0] == 16'(s)));
  end
endmodule

bind shirq_ctrl shirq_ctrl_chk #(.NGRP(NGRP), .NCTX(NCTX), .NPIN(NPIN)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctx_irq(ctx_irq), .pin_irq(pin_irq),
  .pend(pend), .mask(mask), .trig(trig), .pin_vld(pin_vld), .ctx_sel(ctx_sel)
);

// File: tb/sim_shirq_ctrl.sv
`timescale 1ns/1ps
module sim_shirq_ctrl;
  localparam int NGRP = 5, NCTX = 3, NPIN = 4, NS = 40;

  logic clk = 1'b0, rst = 1'b1;
  logic [NS-1:0] src_in = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCTX-1:0] ctx_irq;
  logic [NCTX*NPIN-1:0] pin_irq;

  int total = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  shirq_ctrl #(.NGRP(NGRP), .NCTX(NCTX), .NPIN(NPIN)) u0 (
    .clk(clk), .rst(rst), .src_in(src_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ctx_irq(ctx_irq), .pin_irq(pin_irq));

  function automatic logic [13:0] bank(input int b, input int w);
    return 14'((b << 7) | (w << 2));
  endfunction
  function automatic logic [13:0] pin_a(input int s); return 14'(32'h1000 + 4*s); endfunction
  function automatic logic [13:0] ctx_a(input int s); return 14'(32'h2000 + 4*s); endfunction

  // routing chosen by the bench: source s -> context s%3, pin s%4
  function automatic logic [NCTX-1:0] exp_ctx(input logic [NS-1:0] v);
    logic [NCTX-1:0] r = '0;
    for (int s = 0; s < NS; s++) if (v[s]) r[s % 3] = 1'b1;
    return r;
  endfunction
  function automatic logic [NCTX*NPIN-1:0] exp_pin(input logic [NS-1:0] v);
    logic [NCTX*NPIN-1:0] r = '0;
    for (int s = 0; s < NS; s++) if (v[s]) r[(s % 3)*NPIN + (s % 4)] = 1'b1;
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk_pend(input string req, input logic [NS-1:0] v);
    logic [31:0] d;
    rd(bank(8, 0), d); chk(req, d, v[31:0]);
    rd(bank(8, 1), d); chk(req, d, {24'd0, v[39:32]});
  endtask

  task automatic clear_all();
    for (int s = 0; s < NS; s++) wr(14'h004, 32'(s));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    logic [NS-1:0] pv, iv, a, b, m;
    idle(3); rst = 1'b0; idle(2);

    // ---- R2 / R1 reset state and configuration ----
    chk("R2 ctx_irq", 32'(ctx_irq), 0);
    chk("R2 pin_irq", 32'(pin_irq), 0);
    rd(14'h000, d); chk("R1 cfg", d, 32'h0003_0204);
    chk("R1 count", (32'(d[7:0]) + 1) * 8, NS);
    rd(bank(2, 0), d); chk("R2 pol w0", d, 32'hFFFF_FFFF);
    rd(bank(2, 1), d); chk("R2 pol w1", d, 32'h0000_00FF);
    rd(bank(3, 0), d); chk("R2 trig", d, 0);
    rd(bank(4, 1), d); chk("R2 dual", d, 0);
    rd(bank(7, 0), d); chk("R2 mask", d, 0);
    rd(pin_a(3), d);   chk("R2 pinmap", d, 0);
    rd(ctx_a(7), d);   chk("R2 ctxmap", d, 1);
    rd(bank(5, 0), d); chk("R13 wo read", d, 0);
    rd(14'h0FFC, d);   chk("R13 unmapped", d, 0);

    // ---- R3 / R4 / R9 mask sweep ----
    wr(bank(5, 0), 32'hA5A5_A5A5);
    rd(bank(7, 0), d); chk("R3 set", d, 32'hA5A5_A5A5);
    wr(bank(5, 0), 32'h0000_FFFF);
    rd(bank(7, 0), d); chk("R3 set or", d, 32'hA5A5_FFFF);
    wr(bank(6, 0), 32'h00FF_00FF);
    rd(bank(7, 0), d); chk("R4 clear", d, 32'hA500_FF00);
    wr(bank(5, 1), 32'hFFFF_FFFF);
    rd(bank(7, 1), d); chk("R9 partial word", d, 32'h0000_00FF);
    wr(bank(6, 0), 32'h0);
    rd(bank(7, 0), d); chk("R4 zero write", d, 32'hA500_FF00);
    wr(bank(5, 0), 32'hFFFF_FFFF);

    // routing: source s -> context s%3, pin s%4, valid
    for (int s = 0; s < NS; s++) begin
      wr(pin_a(s), 32'h8000_0000 | 32'(s % 4));
      wr(ctx_a(s), 32'(1 << (s % 3)));
    end
    rd(pin_a(7), d); chk("R10 pinmap rb", d, 32'h8000_0003);

    // ---- R5 level sweep ----
    for (int p = 0; p < 8; p++) begin
      pv = {8'(p * 37 + 5), 32'(p * 32'h9E37_79B9)};
      iv = {8'(p * 91 + 3), 32'(p * 32'h7F4A_7C15 ^ 32'h5A5A_1234)};
      if (p == 6) iv = pv;
      if (p == 7) iv = ~pv;
      wr(bank(2, 0), pv[31:0]); wr(bank(2, 1), {24'd0, pv[39:32]});
      src_in = iv; idle(3);
      m = ~(iv ^ pv);
      chk("R5 level ctx", 32'(ctx_irq), 32'(exp_ctx(m)));
      chk("R5 level pin", 32'(pin_irq), 32'(exp_pin(m)));
      chk_pend("R5 level pend", m);
    end

    // ---- R6 single edge ----
    src_in = '0; idle(2);
    pv = 40'h0F_FF00_33CC; a = 40'hF0_3C96_A55A;
    wr(bank(2, 0), pv[31:0]); wr(bank(2, 1), {24'd0, pv[39:32]});
    wr(bank(3, 0), 32'hFFFF_FFFF); wr(bank(3, 1), 32'hFF);
    chk_pend("R6 none latched", '0);
    src_in = a; idle(3);
    chk_pend("R6 rising", a & pv);
    src_in = '0; idle(3);
    chk_pend("R6 falling", a);
    chk("R6 ctx", 32'(ctx_irq), 32'(exp_ctx(a)));

    // ---- R7 dual edge ----
    clear_all();
    chk_pend("R8 clear all", '0);
    b = 40'h5A_0F0F_F00F;
    wr(bank(4, 0), 32'hFFFF_FFFF); wr(bank(4, 1), 32'hFF);
    src_in = b; idle(3);
    chk_pend("R7 rise both pol", b);
    clear_all();
    src_in = '0; idle(3);
    chk_pend("R7 fall both pol", b);
    clear_all();
    wr(bank(4, 0), 0); wr(bank(4, 1), 0);

    // ---- R8 command word ----
    wr(14'h004, 32'h8000_0025);
    chk_pend("R8 set 37", 40'h20_0000_0000);
    wr(14'h004, 32'h8000_0028);
    wr(14'h004, 32'h8000_8025);
    chk_pend("R8 out of range", 40'h20_0000_0000);
    wr(14'h004, 32'h0000_0025);
    chk_pend("R8 clear 37", '0);
    // level source 33 with high-active polarity, input low
    wr(bank(2, 1), 32'hFF); wr(bank(3, 1), 32'h0);
    wr(14'h004, 32'h8000_0021);
    chk_pend("R8 set level", 40'h02_0000_0000);
    wr(14'h004, 32'h0000_0021);
    chk_pend("R8 clear level", '0);
    src_in[33] = 1'b1; idle(2);
    wr(14'h004, 32'h0000_0021);
    chk_pend("R8 clear active level", 40'h02_0000_0000);
    src_in[33] = 1'b0; wr(bank(3, 1), 32'hFF); idle(2);

    // ---- R10 valid flag / R12 timing / R4 effect ----
    wr(pin_a(5), 32'h0000_0001);
    wr(14'h004, 32'h8000_0005); idle(2);
    chk("R10 invalid ctx", 32'(ctx_irq), 0);
    chk("R10 invalid pin", 32'(pin_irq), 0);
    wr(pin_a(5), 32'h8000_0001); idle(2);
    chk("R12 ctx", 32'(ctx_irq), 32'h4);
    chk("R12 pin", 32'(pin_irq), 32'h200);
    wr(bank(6, 0), 32'h20); idle(2);
    chk("R4 masked ctx", 32'(ctx_irq), 0);
    wr(bank(5, 0), 32'h20); idle(2);
    wr(14'h004, 32'h0000_0005);
    chk("R12 one-cycle hold", 32'(ctx_irq), 32'h4);
    idle(1);
    chk("R12 after clear", 32'(ctx_irq), 0);

    // ---- R11 context map ----
    wr(ctx_a(2), 32'h6);
    rd(ctx_a(2), d); chk("R11 lowest bit", d, 32'h2);
    wr(ctx_a(2), 32'h0);
    rd(ctx_a(2), d); chk("R11 zero ignored", d, 32'h2);
    wr(ctx_a(2), 32'h8);
    rd(ctx_a(2), d); chk("R11 out of range", d, 32'h2);
    wr(14'h004, 32'h8000_0002); idle(2);
    chk("R11 reroute", 32'(ctx_irq), 32'h2);

    done = 1;
    finish_run();
  end
endmodule